// File: doc/BRIEF.md
# Two-Sample-Per-Clock Four-Tap FIR Filter

This block is a four-tap finite impulse response filter that handles two input samples in each clock cycle. An input pair holds an even-phase sample and an odd-phase sample. Both are accepted together with a valid strobe, and two filtered results leave together one cycle later. At a fixed clock rate this gives twice the sample rate of a one-sample-per-clock filter. The cost is a second set of four multipliers.

In each accepted cycle the block takes the sample pair x[2k] (even) and x[2k+1] (odd). It forms y[2k] = c0·x[2k] + c1·x[2k-1] + c2·x[2k-2] + c3·x[2k-3] and the matching odd output y[2k+1]. The window of each output reaches back past the current pair, so the block keeps three earlier samples in registers: the last odd sample, the last even sample, and the odd sample from two pairs back. The coefficients are signed inputs. They are read in the same cycle as the pair they are applied to. The results carry full precision, so no input values can overflow them.

Top module: `fir2p4`

## Requirements
- R1: When `in_valid` is high, `y_even` becomes c0·x[2k] + c1·x[2k-1] + c2·x[2k-2] + c3·x[2k-3] on the next cycle. Here x[2k] is `x_even`, and the older samples are taken from the stream of accepted pairs in arrival order, even before odd.
- R2: When `in_valid` is high, `y_odd` becomes c0·x[2k+1] + c1·x[2k] + c2·x[2k-1] + c3·x[2k-2] on the next cycle. Here x[2k+1] is `x_odd`.
- R3: `out_valid` is high exactly in the cycles that follow a cycle with `in_valid` high and `rst` low, and is low in every other cycle.
- R4: After a cycle with `in_valid` low, `y_even` and `y_odd` keep their previous values, whatever values `x_even`, `x_odd` and the coefficients carry.
- R5: Cycles with `in_valid` low do not change the sample history. The next accepted pair is filtered as if the idle cycles had not occurred.
- R6: A synchronous active-high `rst` sets `out_valid` low and both outputs to zero on the next cycle. It also clears the history to zero, so the first outputs after reset treat earlier samples as zero.
- R7: Samples and coefficients are 16-bit two's complement. Outputs are 34-bit two's complement and exact for all input values. With all samples and coefficients at -32768, each output is 4294967296.
- R8: Each pair is weighted by the coefficient values present in its own accepted cycle. Changing the coefficients between pairs affects only later pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair is valid this cycle |
| x_even | input | 16 | Earlier sample of the pair, x[2k], signed |
| x_odd | input | 16 | Later sample of the pair, x[2k+1], signed |
| coef0 | input | 16 | Weight of the newest sample, signed |
| coef1 | input | 16 | Weight of one-sample-old data, signed |
| coef2 | input | 16 | Weight of two-sample-old data, signed |
| coef3 | input | 16 | Weight of three-sample-old data, signed |
| out_valid | output | 1 | Output pair is valid |
| y_even | output | 34 | y[2k], signed |
| y_odd | output | 34 | y[2k+1], signed |

## Verification
The hardest case to reach is the oldest tap of the even output. That tap reads a sample from two accepted pairs back, which has passed through two history stages. It is only exercised correctly when idle cycles, reset and coefficient changes fall between the pairs that feed it. The stimulus therefore interleaves random idle gaps with random data inside a continuous stream. It drives random values on the sample and coefficient inputs during the idle cycles. It also applies a reset in the middle of a stream and then sends an impulse, so the zero padding of all three history stages is visible at the outputs. Every cycle is compared against a serial model that shifts in one sample at a time.

// File: rtl/fir2p4.sv
module fir2p4 #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int OW = 34
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x_even,
  input  logic signed [DW-1:0] x_odd,
  input  logic signed [CW-1:0] coef0,
  input  logic signed [CW-1:0] coef1,
  input  logic signed [CW-1:0] coef2,
  input  logic signed [CW-1:0] coef3,
  output logic                 out_valid,
  output logic signed [OW-1:0] y_even,
  output logic signed [OW-1:0] y_odd
);
  localparam int TAPS = 4;
  localparam int HN   = TAPS - 1;
  localparam int PW   = DW + CW;

  logic signed [DW-1:0] hist [HN];
  logic signed [DW-1:0] win  [TAPS+1];
  logic signed [CW-1:0] cf   [TAPS];
  logic signed [PW-1:0] pe   [TAPS];
  logic signed [PW-1:0] po   [TAPS];
  logic signed [OW-1:0] sum_e, sum_o;

  assign cf[0] = coef0;
  assign cf[1] = coef1;
  assign cf[2] = coef2;
  assign cf[3] = coef3;

  // newest first: x[2k+1], x[2k], x[2k-1], x[2k-2], x[2k-3]
  assign win[0] = x_odd;
  assign win[1] = x_even;
  for (genvar j = 0; j < HN; j++) begin : g_win
    assign win[j+2] = hist[j];
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign po[i] = cf[i] * win[i];
    assign pe[i] = cf[i] * win[i+1];
  end

  always_comb begin
    sum_e = '0;
    sum_o = '0;
    for (int i = 0; i < TAPS; i++) begin
      sum_e = sum_e + {{(OW-PW){pe[i][PW-1]}}, pe[i]};
      sum_o = sum_o + {{(OW-PW){po[i][PW-1]}}, po[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < HN; j++) hist[j] <= '0;
      out_valid <= 1'b0;
      y_even    <= '0;
      y_odd     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hist[0] <= x_odd;
        hist[1] <= x_even;
        for (int j = 2; j < HN; j++) hist[j] <= hist[j-2];
        y_even <= sum_e;
        y_odd  <= sum_o;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R3
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(y_even) && $stable(y_odd))); // R4
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(hist[0]) && $stable(hist[1]) && $stable(hist[2]))); // R5
  AST_HIST_CHAIN: assert property (@(posedge clk) disable iff (rst) in_valid |=> (hist[2] == $past(hist[0]))); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && y_even == '0 && y_odd == '0 && hist[0] == '0 && hist[1] == '0 && hist[2] == '0)); // R6
endmodule

// File: tb/sim_fir2p4.sv
module sim_fir2p4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] x_even = '0, x_odd = '0;
  logic signed [15:0] coef0 = '0, coef1 = '0, coef2 = '0, coef3 = '0;
  logic out_valid;
  logic signed [33:0] y_even, y_odd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  longint hq[$];
  longint cur_c[4];
  bit     exp_v = 1'b0;
  longint exp_e = 0, exp_o = 0;

  always #4 clk = ~clk;

  fir2p4 u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x_even(x_even), .x_odd(x_odd),
    .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3),
    .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd)
  );

  function automatic longint serial_push(longint s);
    longint acc = 0;
    hq.push_front(s);
    while (hq.size() > 4) void'(hq.pop_back());
    for (int i = 0; i < 4; i++) acc += cur_c[i] * hq[i];
    return acc;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag, bit r, bit v, int xe, int xo,
                       int c0, int c1, int c2, int c3);
    rst = r; in_valid = v;
    x_even = 16'(xe); x_odd = 16'(xo);
    coef0 = 16'(c0); coef1 = 16'(c1); coef2 = 16'(c2); coef3 = 16'(c3);
    if (r) begin
      hq = '{0, 0, 0, 0};
      exp_v = 1'b0; exp_e = 0; exp_o = 0;
    end else if (v) begin
      cur_c[0] = longint'(coef0); cur_c[1] = longint'(coef1);
      cur_c[2] = longint'(coef2); cur_c[3] = longint'(coef3);
      exp_e = serial_push(longint'(x_even));
      exp_o = serial_push(longint'(x_odd));
      exp_v = 1'b1;
    end else begin
      exp_v = 1'b0;
    end
    @(negedge clk);
    check(tag, "out_valid", longint'(out_valid), longint'(exp_v));
    check(tag, "y_even", longint'(y_even), exp_e);
    check(tag, "y_odd", longint'(y_odd), exp_o);
  endtask

  function automatic int rs16();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    int k0, k1, k2, k3;
    @(negedge clk);
    // R6: reset state
    for (int i = 0; i < 3; i++) cycle("R6", 1, 1, 7, 9, 1, 1, 1, 1);
    // R1 R2 R6: impulse after reset shows coefficients and zero padding
    cycle("R1", 0, 1, 1, 0, 1, 2, 3, 4);
    cycle("R2", 0, 1, 0, 0, 1, 2, 3, 4);
    cycle("R1", 0, 1, 0, 1, 1, 2, 3, 4);
    cycle("R2", 0, 1, 0, 0, 1, 2, 3, 4);
    cycle("R2", 0, 1, 0, 0, 1, 2, 3, 4);
    // R1 R2: random stream, fixed coefficients
    k0 = rs16(); k1 = rs16(); k2 = rs16(); k3 = rs16();
    for (int i = 0; i < 200; i++) cycle("R1", 0, 1, rs16(), rs16(), k0, k1, k2, k3);
    // R3 R4 R5: random idle gaps with garbage on the inputs
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) cycle("R4", 0, 0, rs16(), rs16(), rs16(), rs16(), rs16(), rs16());
      else cycle("R5", 0, 1, rs16(), rs16(), k0, k1, k2, k3);
    end
    for (int i = 0; i < 5; i++) cycle("R3", 0, 0, rs16(), rs16(), k0, k1, k2, k3);
    // R8: coefficients change every pair
    for (int i = 0; i < 200; i++) cycle("R8", 0, 1, rs16(), rs16(), rs16(), rs16(), rs16(), rs16());
    // R7: extremes
    for (int i = 0; i < 3; i++) cycle("R7", 0, 1, -32768, -32768, -32768, -32768, -32768, -32768);
    check("R7", "y_even max", longint'(y_even), 64'sd4294967296);
    for (int i = 0; i < 3; i++) cycle("R7", 0, 1, 32767, 32767, -32768, -32768, -32768, -32768);
    for (int i = 0; i < 4; i++) cycle("R7", 0, 1, -32768, 32767, 32767, -32768, 32767, -32768);
    // R6: reset mid-stream, then impulse
    for (int i = 0; i < 10; i++) cycle("R6", 0, 1, rs16(), rs16(), 5, -6, 7, -8);
    cycle("R6", 1, 1, 100, 200, 5, -6, 7, -8);
    cycle("R6", 0, 1, 0, 3, 5, -6, 7, -8);
    cycle("R6", 0, 0, 11, 12, 5, -6, 7, -8);
    cycle("R6", 0, 1, 0, 0, 5, -6, 7, -8);
    cycle("R6", 0, 1, 0, 0, 5, -6, 7, -8);
    cycle("R3", 0, 0, 0, 0, 5, -6, 7, -8);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule